// File: doc/BRIEF.md
# Dynamic Bus Sizing Read Sequencer

This block runs external read cycles on behalf of a 16-bit CPU. The width of each access is set per request, and the bus may be 8 or 16 bits wide. Each request carries an address, a byte/word flag, a flag that marks the target bank as 8 bits wide, and a programmed wait count. The sequencer then drives chip select, output enable, the two byte-lane strobes and the address. It samples the external data and hands one 16-bit result back with a one-cycle done pulse.

Every external read fetches a whole 16-bit word, even when the CPU wants only one byte. On a 16-bit bank that takes one bus cycle. On an 8-bit bank it takes two back-to-back byte cycles, even address first. For a byte request the addressed byte is picked out of the fetched word and the other byte is dropped. An external WAIT input can stretch a bus cycle beyond its programmed length. Writes, DRAM cycles and address decoding are not part of this block.

Top module: `bus_read_seq`

## Requirements
- R1: A request (`req_valid` high at a rising edge) is accepted only while `busy` is low. A request presented while `busy` is high is ignored and does not change the result or the number of done pulses.
- R2: `busy` goes high in the cycle after acceptance and stays high through the done cycle. It is low again in the cycle after done.
- R3: With `req_narrow`=0 (16-bit bank), one bus read is made for both byte and word requests. During that read `bus_addr` equals the request address with bit 0 forced to 0, and `bus_bhe_n` and `bus_ble_n` are both low.
- R4: With `req_narrow`=1 (8-bit bank), two bus reads are made for both byte and word requests. The first uses `bus_addr` bit 0 = 0 and the second uses bit 0 = 1. Only `bus_ble_n` is low and `bus_bhe_n` stays high. Data is taken from `bus_data[7:0]`; the first byte goes to result bits 7:0 and the second to bits 15:8.
- R5: `bus_cs_n` and `bus_oe_n` are low during bus reads, and each bus read lasts `req_wait`+1 cycles when `bus_wait` is low. The two reads on an 8-bit bank follow each other with no idle cycle between them.
- R6: `bus_wait` is looked at only in the last programmed cycle of a bus read. Each cycle it is high there adds one cycle to that read. While programmed wait cycles remain, `bus_wait` has no effect.
- R7: `done` is a one-cycle pulse in the cycle after the last bus read ends. Counted from the accepting edge, `done` is high in cycle reads*(`req_wait`+1) + stretch + 1.
- R8: For a word request (`req_byte`=0), `rd_data` is the full word: bits 7:0 from the even address and bits 15:8 from the odd address. Address bit 0 is ignored.
- R9: For a byte request (`req_byte`=1), `rd_data[7:0]` is the byte at the requested address (even or odd) and `rd_data[15:8]` is 0.
- R10: `rd_data` is 0 whenever `done` is low.
- R11: During and after reset, `busy` and `done` are low, `bus_cs_n`, `bus_oe_n`, `bus_bhe_n` and `bus_ble_n` are high, and `bus_we_n` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | AW | Byte address of the request |
| req_byte | input | 1 | 1 = byte request, 0 = word request |
| req_narrow | input | 1 | 1 = target bank is 8 bits wide |
| req_wait | input | WCW | Programmed wait cycles per bus read |
| busy | output | 1 | Sequencer occupied |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid while done is high |
| bus_addr | output | AW | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, always high |
| bus_bhe_n | output | 1 | High byte lane strobe, active low |
| bus_ble_n | output | 1 | Low byte lane strobe, active low |
| bus_wait | input | 1 | External wait request, active high |
| bus_data | input | 16 | External read data |

## Verification
The embedded assertions check lane-strobe legality on every output-enable cycle for both bank widths, that chip select covers output enable, that `busy` is held until done, that done is a single-cycle pulse, and that the result is zeroed outside done with the upper byte clear on byte results. Several things can be shown only by the bench's scenarios against a memory model: the cycle counts of each bus read, when WAIT is honoured or ignored, the even-then-odd ordering and byte placement on an 8-bit bank, byte selection, and that a request made while busy is dropped.

// File: rtl/bus_read_seq.sv
module bus_read_seq #(
  parameter int AW  = 20,
  parameter int WCW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_byte,
  input  logic           req_narrow,
  input  logic [WCW-1:0] req_wait,
  output logic           busy,
  output logic           done,
  output logic [15:0]    rd_data,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_cs_n,
  output logic           bus_oe_n,
  output logic           bus_we_n,
  output logic           bus_bhe_n,
  output logic           bus_ble_n,
  input  logic           bus_wait,
  input  logic [15:0]    bus_data
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_DONE} st_t;

  st_t            state;
  logic [AW-1:0]  addr_q;
  logic           byte_q, narrow_q, half;
  logic [WCW-1:0] wait_q, cnt;
  logic [15:0]    word_q;

  wire rd     = (state == S_RD);
  wire finish = rd && (cnt == '0) && !bus_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      byte_q   <= 1'b0;
      narrow_q <= 1'b0;
      half     <= 1'b0;
      wait_q   <= '0;
      cnt      <= '0;
      word_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q   <= req_addr;
          byte_q   <= req_byte;
          narrow_q <= req_narrow;
          wait_q   <= req_wait;
          cnt      <= req_wait;
          half     <= 1'b0;
          state    <= S_RD;
        end
        S_RD: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (finish) begin
            if (!narrow_q) word_q <= bus_data;
            else if (!half) word_q[7:0] <= bus_data[7:0];
            else word_q[15:8] <= bus_data[7:0];
            if (narrow_q && !half) begin
              half <= 1'b1;
              cnt  <= wait_q;
            end else begin
              state <= S_DONE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  wire [7:0] pick = addr_q[0] ? word_q[15:8] : word_q[7:0];

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign rd_data   = !done ? 16'h0 : (byte_q ? {8'h00, pick} : word_q);
  assign bus_addr  = {addr_q[AW-1:1], narrow_q & half};
  assign bus_cs_n  = !rd;
  assign bus_oe_n  = !rd;
  assign bus_we_n  = 1'b1;
  assign bus_bhe_n = !(rd && !narrow_q);
  assign bus_ble_n = !rd;

  // R1
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R3
  wide_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n && !narrow_q) |-> (!bus_bhe_n && !bus_ble_n && !bus_addr[0]));
  // R4
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n && narrow_q) |-> (bus_bhe_n && !bus_ble_n));
  // R5
  cs_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> !bus_cs_n);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && byte_q) |-> (rd_data[15:8] == 8'h00));
  // R10
  data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (rd_data == 16'h0));

endmodule

// File: tb/bus_read_seq_test.sv
module bus_read_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_byte = 1'b0, req_narrow = 1'b0;
  logic [3:0]  req_wait = '0;
  logic        busy, done;
  logic [15:0] rd_data;
  logic [19:0] bus_addr;
  logic        bus_cs_n, bus_oe_n, bus_we_n, bus_bhe_n, bus_ble_n;
  logic        bus_wait = 1'b0;
  logic [15:0] bus_data;

  int checks = 0, errors = 0;
  logic        cur_narrow = 1'b0;
  int          wext = 0;
  int          oe_cnt = 0;
  logic [19:0] first_a, last_a;
  logic        lane_bad = 1'b0;

  always #2 clk = ~clk;

  bus_read_seq uut (.*);

  function automatic logic [7:0] bval(input logic [19:0] a);
    return a[7:0] ^ {a[3:0], a[7:4]} ^ 8'hA5 ^ a[15:8];
  endfunction

  assign bus_data = cur_narrow ? {8'hEE, bval(bus_addr)}
                               : {bval({bus_addr[19:1], 1'b1}), bval({bus_addr[19:1], 1'b0})};

  always @(negedge clk) begin
    if (!bus_oe_n) begin
      oe_cnt = oe_cnt + 1;
      if (oe_cnt == 1) first_a = bus_addr;
      last_a = bus_addr;
      if (bus_cs_n) lane_bad = 1'b1;
      if (cur_narrow ? !(bus_bhe_n && !bus_ble_n) : !(!bus_bhe_n && !bus_ble_n)) lane_bad = 1'b1;
      bus_wait <= (oe_cnt <= wext);
    end else bus_wait <= 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [19:0] a, input logic b, input logic n, input logic [3:0] w,
                         input int ext_drive, input int exp_ext, input logic intrude);
    int cyc = 0;
    int reads = n ? 2 : 1;
    logic busy_ok = 1'b1;
    logic [19:0] al = {a[19:1], 1'b0};
    logic [15:0] exp_d = b ? {8'h00, bval(a)} : {bval({a[19:1], 1'b1}), bval(al)};
    logic [15:0] got = '0;
    @(negedge clk);
    oe_cnt = 0; lane_bad = 1'b0; wext = ext_drive; cur_narrow = n;
    req_addr = a; req_byte = b; req_narrow = n; req_wait = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 200) begin
      if (!busy) busy_ok = 1'b0;
      if (intrude && cyc == 2) begin
        req_valid = 1'b1; req_addr = a ^ 20'h00F0F; req_byte = ~b;
      end else req_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    got = rd_data;
    chk("R8/R9 data", {16'h0, got}, {16'h0, exp_d});
    chk("R7 latency", cyc, reads * (w + 1) + exp_ext + 1);
    chk("R5/R6 oe cycles", oe_cnt, reads * (w + 1) + exp_ext);
    chk("R3/R4 first addr", {12'h0, first_a}, {12'h0, al});
    chk("R3/R4 last addr", {12'h0, last_a}, {12'h0, al | {19'h0, n}});
    chk("R3/R4 lane strobes", {31'h0, lane_bad}, 32'h0);
    chk("R2 busy held", {31'h0, busy_ok & busy}, 32'h1);
    @(negedge clk);
    chk("R2/R7 idle after done", {30'h0, busy, done}, 32'h0);
    if (intrude) chk("R1 no second done", {31'h0, done}, 32'h0);
  endtask

  localparam logic [25:0] VEC [0:7] = '{
    {20'h00010, 1'b0, 1'b0, 4'd0},
    {20'h00123, 1'b1, 1'b0, 4'd1},
    {20'h00456, 1'b1, 1'b0, 4'd2},
    {20'h00457, 1'b0, 1'b0, 4'd0},
    {20'h0ABC4, 1'b0, 1'b1, 4'd0},
    {20'h0ABC5, 1'b1, 1'b1, 4'd2},
    {20'h0ABC6, 1'b1, 1'b1, 4'd1},
    {20'hFFFFF, 1'b0, 1'b1, 4'd15}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R11 in reset
    chk("R11 reset busy/done", {30'h0, busy, done}, 32'h0);
    chk("R11 reset strobes", {27'h0, bus_cs_n, bus_oe_n, bus_bhe_n, bus_ble_n, bus_we_n}, 32'h1F);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 after reset strobes", {27'h0, bus_cs_n, bus_oe_n, bus_bhe_n, bus_ble_n, bus_we_n}, 32'h1F);
    chk("R10 idle data", {16'h0, rd_data}, 32'h0);

    for (int i = 0; i < 8; i++)
      do_read(VEC[i][25:6], VEC[i][5], VEC[i][4], VEC[i][3:0], 0, 0, 1'b0);

    // R6: WAIT stretches last cycle by 3
    do_read(20'h01230, 1'b0, 1'b0, 4'd0, 3, 3, 1'b0);
    // R6: WAIT ignored while programmed count remains
    do_read(20'h01232, 1'b1, 1'b0, 4'd3, 2, 0, 1'b0);
    // R1: request while busy ignored
    do_read(20'h02345, 1'b1, 1'b1, 4'd2, 0, 0, 1'b1);
    do_read(20'h03000, 1'b0, 1'b0, 4'd4, 0, 0, 1'b1);
    chk("R11 we_n high", {31'h0, bus_we_n}, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule